// File: doc/BRIEF.md
# Banked Byte Data Memory with Access Window

This block is the data store of a small 8-bit controller core. It forms a 12-bit effective byte address in one of three ways. A 4-bit bank number can be prefixed to an 8-bit instruction operand. An access-window mapping can send low operands to the bottom of the space and high operands to the top, whatever bank is selected. A full-width pointer can address any location directly. Only two 256-byte banks exist. Bank 0 holds general purpose RAM. The top of bank 15 holds a small array of special function registers. Every other address reads as zero and ignores writes.

The core sees a read port with one cycle of latency, a write port, the bank and pointer registers, and a two-cycle register-to-register move engine. The move engine reads any 12-bit source address and then writes any 12-bit destination address. While it runs, it owns both memory ports.

Top module: `dmem_core`

## Requirements
- R1: In mode 0 (banked), the effective address is {bank[3:0], operand}. Read data appears on `rd_data` in the cycle after the request and holds until the next accepted read.
- R2: Only the low 4 bits of the bank register are stored. `bsr_q[7:4]` always reads 0. After reset, `bsr_q` is 0x00 and `ptr_q` is 0x000.
- R3: In mode 1 (access window), operands 0x00–0x7F address 0x000–0x07F and operands 0x80–0xFF address 0xF80–0xFFF. The bank register has no effect in this mode.
- R4: In modes 2 and 3 (indirect), the effective address is the 12-bit pointer. The operand and the bank register are ignored.
- R5: Addresses 0x000–0x0FF are read/write general purpose RAM.
- R6: Special function registers are implemented at 0xFE0–0xFFF and reset to 0x00. Slots 0xF80–0xFDF read 0x00, and writes to them are dropped.
- R7: Addresses 0x100–0xF7F read 0x00. Writes to them are dropped and never alias into an implemented location.
- R8: A read and a write to the same address in the same cycle return the old data. The new data is visible to later reads.
- R9: A move start accepted while idle drives `mv_busy` high for exactly the next two cycles. The byte at the 12-bit source address is then found at the 12-bit destination address, across banks.
- R10: While `mv_busy` is high, new move starts and external read and write requests are ignored.
- R11: General purpose RAM keeps its contents through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bsr_we | input | 1 | Load bank register |
| bsr_wdata | input | 8 | Bank register write value |
| bsr_q | output | 8 | Bank register value (upper nibble zero) |
| ptr_we | input | 1 | Load pointer register |
| ptr_wdata | input | 12 | Pointer write value |
| ptr_q | output | 12 | Pointer register value |
| rd_en | input | 1 | Read request |
| rd_mode | input | 2 | Read addressing mode (0 banked, 1 window, 2/3 pointer) |
| rd_opnd | input | 8 | Read operand |
| rd_data | output | 8 | Read data, one cycle after the request |
| wr_en | input | 1 | Write request |
| wr_mode | input | 2 | Write addressing mode |
| wr_opnd | input | 8 | Write operand |
| wr_data | input | 8 | Write data |
| mv_start | input | 1 | Start a register-to-register move |
| mv_src | input | 12 | Move source address |
| mv_dst | input | 12 | Move destination address |
| mv_busy | output | 1 | Move in progress |

## Verification
Two functions can land in one clock: an external read and an external write to the same location, and the move engine's read or write colliding with fresh external requests. The first case is provoked by pointing both ports at one RAM byte and then at one special register in a single cycle. The check passes when `rd_data` shows the earlier value and a follow-up read shows the new one. The second case is provoked by holding a second start and an external write to a known byte through both busy cycles. The check passes when the move delivers the right byte to the right place, the second destination is untouched, and the externally targeted byte keeps its prior value.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [1:0] {
    AM_BANKED   = 2'd0,
    AM_WINDOW   = 2'd1,
    AM_POINTER  = 2'd2,
    AM_POINTER2 = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_GPR  = 2'd1,
    RG_SFR  = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mvstate_e;

endpackage

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dmem_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int OPND_W       = 8,
  parameter int WINDOW_SPLIT = 128
) (
  input  logic [1:0]               mode,
  input  logic [OPND_W-1:0]        opnd,
  input  logic [ADDR_W-OPND_W-1:0] bank,
  input  logic [ADDR_W-1:0]        ptr,
  output logic [ADDR_W-1:0]        addr
);

  localparam int BANK_W = ADDR_W - OPND_W;
  localparam logic [OPND_W-1:0] SPLIT = OPND_W'(WINDOW_SPLIT);

  amode_e am;
  assign am = amode_e'(mode);

  always_comb begin
    unique case (am)
      AM_BANKED: addr = {bank, opnd};
      AM_WINDOW: begin
        if (opnd < SPLIT) addr = {{BANK_W{1'b0}}, opnd};
        else              addr = {{BANK_W{1'b1}}, opnd};
      end
      default:   addr = ptr;
    endcase
  end

endmodule

// File: rtl/dmem_region_dec.sv
module dmem_region_dec
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int GPR_DEPTH = 256,
  parameter int SFR_COUNT = 32
) (
  input  logic [ADDR_W-1:0]            addr,
  output region_e                      region,
  output logic [$clog2(GPR_DEPTH)-1:0] gpr_idx,
  output logic [$clog2(SFR_COUNT)-1:0] sfr_idx
);

  localparam int GPR_AW = $clog2(GPR_DEPTH);
  localparam int SFR_AW = $clog2(SFR_COUNT);
  localparam logic [ADDR_W:0]   GPR_LIMIT = (ADDR_W+1)'(GPR_DEPTH);
  localparam logic [ADDR_W-1:0] SFR_BASE  = ADDR_W'((2 ** ADDR_W) - SFR_COUNT);

  always_comb begin
    if ({1'b0, addr} < GPR_LIMIT)  region = RG_GPR;
    else if (addr >= SFR_BASE)     region = RG_SFR;
    else                           region = RG_NONE;
  end

  assign gpr_idx = addr[GPR_AW-1:0];
  assign sfr_idx = addr[SFR_AW-1:0];

endmodule

// File: rtl/dmem_sram.sv
module dmem_sram #(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 256,
  parameter bit CLEAR_ON_RST = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  generate
    if (CLEAR_ON_RST) begin : g_regs
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
          rdata <= '0;
        end else begin
          if (we) mem[waddr] <= wdata;
          if (re) rdata <= mem[raddr];
        end
      end
    end else begin : g_ram
      always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
      end
      always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
      end
    end
  endgenerate

endmodule

// File: rtl/dmem_move_seq.sv
module dmem_move_seq
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              busy,
  output logic              rd_req,
  output logic              wr_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr
);

  mvstate_e          state;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= MV_IDLE;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      unique case (state)
        MV_IDLE: begin
          if (start) begin
            src_q <= src;
            dst_q <= dst;
            state <= MV_READ;
          end
        end
        MV_READ:  state <= MV_WRITE;
        default:  state <= MV_IDLE;
      endcase
    end
  end

  assign busy    = (state != MV_IDLE);
  assign rd_req  = (state == MV_READ);
  assign wr_req  = (state == MV_WRITE);
  assign rd_addr = src_q;
  assign wr_addr = dst_q;

endmodule

// File: rtl/dmem_core.sv
module dmem_core
  import dmem_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 12,
  parameter int OPND_W       = 8,
  parameter int BSR_W        = 8,
  parameter int BSR_IMPL     = 4,
  parameter int GPR_DEPTH    = 256,
  parameter int SFR_COUNT    = 32,
  parameter int WINDOW_SPLIT = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bsr_we,
  input  logic [BSR_W-1:0]  bsr_wdata,
  output logic [BSR_W-1:0]  bsr_q,
  input  logic              ptr_we,
  input  logic [ADDR_W-1:0] ptr_wdata,
  output logic [ADDR_W-1:0] ptr_q,
  input  logic              rd_en,
  input  logic [1:0]        rd_mode,
  input  logic [OPND_W-1:0] rd_opnd,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic [OPND_W-1:0] wr_opnd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mv_start,
  input  logic [ADDR_W-1:0] mv_src,
  input  logic [ADDR_W-1:0] mv_dst,
  output logic              mv_busy
);

  localparam int BANK_W = ADDR_W - OPND_W;
  localparam int GPR_AW = $clog2(GPR_DEPTH);
  localparam int SFR_AW = $clog2(SFR_COUNT);

  // bank and pointer registers
  logic [BSR_IMPL-1:0] bank_lo;
  logic [ADDR_W-1:0]   ptr_r;
  logic [BSR_W-BSR_IMPL-1:0] unused_bsr_hi;

  assign unused_bsr_hi = bsr_wdata[BSR_W-1:BSR_IMPL];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_lo <= '0;
      ptr_r   <= '0;
    end else begin
      if (bsr_we) bank_lo <= bsr_wdata[BSR_IMPL-1:0];
      if (ptr_we) ptr_r   <= ptr_wdata;
    end
  end

  assign bsr_q = {{(BSR_W-BSR_IMPL){1'b0}}, bank_lo};
  assign ptr_q = ptr_r;

  logic [BANK_W-1:0] bank_field;
  assign bank_field = BANK_W'(bank_lo);

  // effective address generation, one per port
  logic [ADDR_W-1:0] ext_raddr;
  logic [ADDR_W-1:0] ext_waddr;

  dmem_addr_gen #(.ADDR_W(ADDR_W), .OPND_W(OPND_W), .WINDOW_SPLIT(WINDOW_SPLIT)) rd_ag_i (
    .mode (rd_mode),
    .opnd (rd_opnd),
    .bank (bank_field),
    .ptr  (ptr_r),
    .addr (ext_raddr)
  );

  dmem_addr_gen #(.ADDR_W(ADDR_W), .OPND_W(OPND_W), .WINDOW_SPLIT(WINDOW_SPLIT)) wr_ag_i (
    .mode (wr_mode),
    .opnd (wr_opnd),
    .bank (bank_field),
    .ptr  (ptr_r),
    .addr (ext_waddr)
  );

  // move sequencer
  logic              mv_rd_req;
  logic              mv_wr_req;
  logic [ADDR_W-1:0] mv_rd_addr;
  logic [ADDR_W-1:0] mv_wr_addr;

  dmem_move_seq #(.ADDR_W(ADDR_W)) mv_i (
    .clk     (clk),
    .rst     (rst),
    .start   (mv_start),
    .src     (mv_src),
    .dst     (mv_dst),
    .busy    (mv_busy),
    .rd_req  (mv_rd_req),
    .wr_req  (mv_wr_req),
    .rd_addr (mv_rd_addr),
    .wr_addr (mv_wr_addr)
  );

  // port arbitration: the sequencer owns both ports while busy
  logic              eff_re;
  logic              eff_we;
  logic [ADDR_W-1:0] eff_raddr;
  logic [ADDR_W-1:0] eff_waddr;
  logic [DATA_W-1:0] eff_wdata;

  always_comb begin
    if (mv_busy) begin
      eff_re    = mv_rd_req;
      eff_raddr = mv_rd_addr;
      eff_we    = mv_wr_req;
      eff_waddr = mv_wr_addr;
      eff_wdata = rd_data;
    end else begin
      eff_re    = rd_en;
      eff_raddr = ext_raddr;
      eff_we    = wr_en;
      eff_waddr = ext_waddr;
      eff_wdata = wr_data;
    end
  end

  // region decode
  region_e           rd_region;
  region_e           wr_region;
  logic [GPR_AW-1:0] rd_gpr_idx;
  logic [GPR_AW-1:0] wr_gpr_idx;
  logic [SFR_AW-1:0] rd_sfr_idx;
  logic [SFR_AW-1:0] wr_sfr_idx;

  dmem_region_dec #(.ADDR_W(ADDR_W), .GPR_DEPTH(GPR_DEPTH), .SFR_COUNT(SFR_COUNT)) rd_dec_i (
    .addr    (eff_raddr),
    .region  (rd_region),
    .gpr_idx (rd_gpr_idx),
    .sfr_idx (rd_sfr_idx)
  );

  dmem_region_dec #(.ADDR_W(ADDR_W), .GPR_DEPTH(GPR_DEPTH), .SFR_COUNT(SFR_COUNT)) wr_dec_i (
    .addr    (eff_waddr),
    .region  (wr_region),
    .gpr_idx (wr_gpr_idx),
    .sfr_idx (wr_sfr_idx)
  );

  // storage arrays
  logic [DATA_W-1:0] gpr_rdata;
  logic [DATA_W-1:0] sfr_rdata;
  logic              gpr_we;
  logic              sfr_we;
  logic              gpr_re;
  logic              sfr_re;

  assign gpr_we = eff_we && (wr_region == RG_GPR);
  assign sfr_we = eff_we && (wr_region == RG_SFR);
  assign gpr_re = eff_re && (rd_region == RG_GPR);
  assign sfr_re = eff_re && (rd_region == RG_SFR);

  dmem_sram #(.DATA_W(DATA_W), .DEPTH(GPR_DEPTH), .CLEAR_ON_RST(1'b0)) gpr_i (
    .clk   (clk),
    .rst   (rst),
    .we    (gpr_we),
    .waddr (wr_gpr_idx),
    .wdata (eff_wdata),
    .re    (gpr_re),
    .raddr (rd_gpr_idx),
    .rdata (gpr_rdata)
  );

  dmem_sram #(.DATA_W(DATA_W), .DEPTH(SFR_COUNT), .CLEAR_ON_RST(1'b1)) sfr_i (
    .clk   (clk),
    .rst   (rst),
    .we    (sfr_we),
    .waddr (wr_sfr_idx),
    .wdata (eff_wdata),
    .re    (sfr_re),
    .raddr (rd_sfr_idx),
    .rdata (sfr_rdata)
  );

  // read return: region of the last accepted read selects the array output
  region_e sel_q;

  always_ff @(posedge clk) begin
    if (rst)         sel_q <= RG_NONE;
    else if (eff_re) sel_q <= rd_region;
  end

  always_comb begin
    unique case (sel_q)
      RG_GPR:  rd_data = gpr_rdata;
      RG_SFR:  rd_data = sfr_rdata;
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dmem_core_chk.sv
module dmem_core_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 12,
  parameter int BSR_W     = 8,
  parameter int BSR_IMPL  = 4,
  parameter int GPR_DEPTH = 256,
  parameter int SFR_COUNT = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [BSR_W-1:0]  bsr_q,
  input logic [ADDR_W-1:0] ptr_q,
  input logic              rd_en,
  input logic [1:0]        rd_mode,
  input logic [DATA_W-1:0] rd_data,
  input logic              mv_start,
  input logic              mv_busy
);

  localparam logic [ADDR_W-1:0] GAP_LO = ADDR_W'(GPR_DEPTH);
  localparam logic [ADDR_W-1:0] GAP_HI = ADDR_W'((2 ** ADDR_W) - SFR_COUNT);
  localparam logic [BSR_IMPL-1:0] TOP_BANK = '1;

  // R2
  bsr_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bsr_q[BSR_W-1:BSR_IMPL] == '0);

  // R2
  reset_values_chk: assert property (@(posedge clk)
    rst |=> (bsr_q == '0 && ptr_q == '0 && rd_data == '0));

  // R7
  gap_ptr_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mv_busy && rd_mode[1] && ptr_q >= GAP_LO && ptr_q < GAP_HI)
      |=> rd_data == '0);

  // R7
  gap_bank_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mv_busy && rd_mode == 2'd0 &&
     bsr_q[BSR_IMPL-1:0] != '0 && bsr_q[BSR_IMPL-1:0] != TOP_BANK)
      |=> rd_data == '0);

  // R9
  move_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!mv_busy && mv_start) |=> mv_busy);

  // R9
  move_two_cycles_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_busy && $past(mv_busy)) |=> !mv_busy);

  // R10
  move_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (mv_busy && !$past(mv_busy)) |=> mv_busy);

endmodule

bind dmem_core dmem_core_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BSR_W(BSR_W), .BSR_IMPL(BSR_IMPL),
  .GPR_DEPTH(GPR_DEPTH), .SFR_COUNT(SFR_COUNT)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bsr_q    (bsr_q),
  .ptr_q    (ptr_q),
  .rd_en    (rd_en),
  .rd_mode  (rd_mode),
  .rd_data  (rd_data),
  .mv_start (mv_start),
  .mv_busy  (mv_busy)
);

// File: tb/dmem_core_tb.sv
module dmem_core_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        bsr_we;
  logic [7:0]  bsr_wdata;
  logic [7:0]  bsr_q;
  logic        ptr_we;
  logic [11:0] ptr_wdata;
  logic [11:0] ptr_q;
  logic        rd_en;
  logic [1:0]  rd_mode;
  logic [7:0]  rd_opnd;
  logic [7:0]  rd_data;
  logic        wr_en;
  logic [1:0]  wr_mode;
  logic [7:0]  wr_opnd;
  logic [7:0]  wr_data;
  logic        mv_start;
  logic [11:0] mv_src;
  logic [11:0] mv_dst;
  logic        mv_busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dmem_core dut_i (
    .clk(clk), .rst(rst),
    .bsr_we(bsr_we), .bsr_wdata(bsr_wdata), .bsr_q(bsr_q),
    .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .ptr_q(ptr_q),
    .rd_en(rd_en), .rd_mode(rd_mode), .rd_opnd(rd_opnd), .rd_data(rd_data),
    .wr_en(wr_en), .wr_mode(wr_mode), .wr_opnd(wr_opnd), .wr_data(wr_data),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_busy(mv_busy)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_bsr(input logic [7:0] v);
    bsr_we = 1'b1; bsr_wdata = v;
    @(negedge clk);
    bsr_we = 1'b0;
  endtask

  task automatic set_ptr(input logic [11:0] v);
    ptr_we = 1'b1; ptr_wdata = v;
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic do_write(input logic [1:0] m, input logic [7:0] op, input logic [7:0] d);
    wr_en = 1'b1; wr_mode = m; wr_opnd = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] m, input logic [7:0] op, output logic [7:0] d);
    rd_en = 1'b1; rd_mode = m; rd_opnd = op;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic write_at(input logic [11:0] a, input logic [7:0] d);
    set_ptr(a);
    do_write(2'd2, 8'h00, d);
  endtask

  task automatic read_at(input logic [11:0] a, output logic [7:0] d);
    set_ptr(a);
    do_read(2'd2, 8'h00, d);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk("R2 bank reg after reset", 12'(bsr_q), 12'h000);
    chk("R2 pointer after reset", ptr_q, 12'h000);
    chk("R2 read data after reset", 12'(rd_data), 12'h000);
    read_at(12'hFFF, d);
    chk("R6 special reg reset value", 12'(d), 12'h000);
  endtask

  task automatic t_bank_reg();
    set_bsr(8'hAF);
    chk("R2 upper nibble dropped", 12'(bsr_q), 12'h00F);
    set_bsr(8'h00);
  endtask

  task automatic t_banked();
    logic [7:0] d;
    set_bsr(8'h00);
    do_write(2'd0, 8'h10, 8'h5A);
    do_read(2'd0, 8'h10, d);
    chk("R1 banked bank0 readback", 12'(d), 12'h05A);
    read_at(12'h010, d);
    chk("R5 ram byte via pointer", 12'(d), 12'h05A);
    set_bsr(8'h05);
    do_write(2'd0, 8'h10, 8'h77);
    do_read(2'd0, 8'h10, d);
    chk("R7 bank5 reads zero", 12'(d), 12'h000);
    read_at(12'h510, d);
    chk("R7 0x510 reads zero", 12'(d), 12'h000);
    read_at(12'h010, d);
    chk("R7 no alias into bank0", 12'(d), 12'h05A);
    write_at(12'h0FF, 8'h3C);
    set_bsr(8'h00);
    do_read(2'd0, 8'hFF, d);
    chk("R5 top ram byte", 12'(d), 12'h03C);
  endtask

  task automatic t_window();
    logic [7:0] d;
    set_bsr(8'h05);
    do_write(2'd1, 8'h20, 8'h33);
    read_at(12'h020, d);
    chk("R3 low window to 0x020", 12'(d), 12'h033);
    do_write(2'd1, 8'hF0, 8'h44);
    read_at(12'hFF0, d);
    chk("R3 high window to 0xFF0", 12'(d), 12'h044);
    set_bsr(8'h0F);
    do_read(2'd0, 8'hF0, d);
    chk("R1 bank15 banked read", 12'(d), 12'h044);
    do_read(2'd1, 8'h7F, d);
    write_at(12'h07F, 8'h61);
    set_bsr(8'h09);
    do_read(2'd1, 8'h7F, d);
    chk("R3 window split edge 0x7F", 12'(d), 12'h061);
    set_bsr(8'h00);
  endtask

  task automatic t_sfr();
    logic [7:0] d;
    write_at(12'hFA0, 8'h99);
    read_at(12'hFA0, d);
    chk("R6 unused slot reads zero", 12'(d), 12'h000);
    write_at(12'hF40, 8'h98);
    read_at(12'hF40, d);
    chk("R7 bank15 low half zero", 12'(d), 12'h000);
    write_at(12'hFE0, 8'h12);
    read_at(12'hFE0, d);
    chk("R6 lowest implemented slot", 12'(d), 12'h012);
    write_at(12'hFDF, 8'h13);
    read_at(12'hFDF, d);
    chk("R6 slot below boundary zero", 12'(d), 12'h000);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    set_bsr(8'h03);
    set_ptr(12'h030);
    do_write(2'd2, 8'hC7, 8'h4E);
    do_read(2'd3, 8'h11, d);
    chk("R4 pointer ignores operand and bank", 12'(d), 12'h04E);
    set_bsr(8'h00);
    do_read(2'd0, 8'h30, d);
    chk("R4 landed at 0x030", 12'(d), 12'h04E);
  endtask

  task automatic t_same_cycle(input logic [11:0] a, input string tag);
    logic [7:0] d;
    write_at(a, 8'h11);
    rd_en = 1'b1; rd_mode = 2'd2; rd_opnd = 8'h00;
    wr_en = 1'b1; wr_mode = 2'd2; wr_opnd = 8'h00; wr_data = 8'h22;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk(tag, 12'(rd_data), 12'h011);
    do_read(2'd2, 8'h00, d);
    chk(tag, 12'(d), 12'h022);
  endtask

  task automatic t_move(input logic [11:0] src, input logic [11:0] dst,
                        input logic [7:0] val, input bit interfere);
    logic [7:0] d;
    write_at(src, val);
    if (interfere) begin
      write_at(12'h061, 8'h00);
      write_at(12'h060, 8'h9E);
    end
    mv_start = 1'b1; mv_src = src; mv_dst = dst;
    @(negedge clk);
    mv_start = 1'b0;
    chk("R9 busy first cycle", 12'(mv_busy), 12'h001);
    if (interfere) begin
      mv_start = 1'b1; mv_src = 12'h060; mv_dst = 12'h061;
      wr_en = 1'b1; wr_mode = 2'd2; wr_data = 8'hEE;
    end
    @(negedge clk);
    chk("R9 busy second cycle", 12'(mv_busy), 12'h001);
    @(negedge clk);
    mv_start = 1'b0; wr_en = 1'b0;
    chk("R9 idle after move", 12'(mv_busy), 12'h000);
    read_at(dst, d);
    chk("R9 destination holds source byte", 12'(d), 12'(val));
    if (interfere) begin
      read_at(12'h060, d);
      chk("R10 external write ignored", 12'(d), 12'h09E);
      read_at(12'h061, d);
      chk("R10 second start ignored", 12'(d), 12'h000);
    end
  endtask

  task automatic t_reset_keep();
    logic [7:0] d;
    write_at(12'h070, 8'hA5);
    write_at(12'hFFC, 8'h5C);
    do_reset();
    read_at(12'h070, d);
    chk("R11 ram survives reset", 12'(d), 12'h0A5);
    read_at(12'hFFC, d);
    chk("R6 special reg cleared by reset", 12'(d), 12'h000);
  endtask

  initial begin
    rst = 1'b1;
    bsr_we = 1'b0; bsr_wdata = '0; ptr_we = 1'b0; ptr_wdata = '0;
    rd_en = 1'b0; rd_mode = '0; rd_opnd = '0;
    wr_en = 1'b0; wr_mode = '0; wr_opnd = '0; wr_data = '0;
    mv_start = 1'b0; mv_src = '0; mv_dst = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_bank_reg();
    t_banked();
    t_window();
    t_sfr();
    t_pointer();
    t_same_cycle(12'h040, "R8 ram read-before-write");
    t_same_cycle(12'hFF8, "R8 special reg read-before-write");
    t_move(12'h050, 12'hFFC, 8'hC3, 1'b0);
    t_move(12'hFFC, 12'h0A0, 8'h6D, 1'b0);
    t_move(12'h055, 12'h0B0, 8'h2B, 1'b1);
    t_reset_keep();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule